// File: doc/BRIEF.md
# Front Panel Abort and LED Control

This block sits behind a byte-wide register port and handles a front-panel abort push-button and a pair of health lamps. The raw button input is brought into the clock domain through a two-flop synchronizer and then debounced: a new level is accepted only after the synchronized input has disagreed with the accepted level for an unbroken run of 2^DEBOUNCE_BITS clock cycles. When the accepted level goes from released to pressed and the abort function is enabled, a sticky pending flag is set. The interrupt output is high while that flag and the enable are both set.

Two 8-bit registers are reachable. The abort register holds the enable bit, shows the pending flag and shows the state of a CMOS-clear jumper. Writing the enable bit as 0 clears the pending flag and disables the abort in the same write. The LED register drives a fault lamp and a pass lamp, whose control bits have opposite polarity. Out of reset both lamps are lit, so that firmware can switch off the fault lamp once its self-test has passed. Reads are combinational from the selected register. Bits with no defined function read as zero.

Top module: `fp_abort_led`

## Requirements
- R1: After reset, the abort register reads 0x80 with the jumper not fitted, the LED register reads 0x02, `fault_led_on` and `pass_led_on` are both 1 and `abort_irq` is 0.
- R2: In the LED register, bit 0 controls the fault lamp with inverted sense (`fault_led_on` = NOT bit 0) and bit 1 controls the pass lamp with direct sense (`pass_led_on` = bit 1). Both bits read back as written, and bits 7..2 always read 0.
- R3: Writing the abort register with bit 5 = 1 enables the abort function. Bit 5 reads back the enable state, and the enable state is 0 after reset.
- R4: The synchronized button level is accepted only after it has differed from the accepted level for 2^DEBOUNCE_BITS consecutive cycles. A pulse shorter than that has no effect on the pending flag.
- R5: An accepted press edge (released to pressed) sets the pending flag, read as abort register bit 4. The flag stays set until it is cleared by a write. Holding the button down does not create new edges, and rewriting bit 5 = 1 does not clear the flag.
- R6: Writing the abort register with bit 5 = 0 clears the pending flag and the enable state, and drops `abort_irq` on the next cycle.
- R7: `abort_irq` is 1 exactly when the pending flag and the enable state are both 1.
- R8: Abort register bit 7 reads 0 while `cmos_jumper_fitted` is 1 and reads 1 otherwise. Bits 6, 3..0 read 0, and writes have no effect on bits 7, 6, 4 and 3..0.
- R9: With both selects high, a read returns the abort register. With neither select high, a read returns 0. A write goes to every register whose select is high.
- R10: A press edge accepted while the abort function is disabled does not set the pending flag. Enabling the abort while the button is already held does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_abort | input | 1 | Selects the abort register |
| sel_led | input | 1 | Selects the LED register |
| wr_en | input | 1 | Write strobe for the selected register(s) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| abort_btn_raw | input | 1 | Raw, asynchronous abort button, 1 = pressed |
| cmos_jumper_fitted | input | 1 | CMOS-clear jumper sense, 1 = fitted |
| abort_irq | output | 1 | Abort interrupt request |
| fault_led_on | output | 1 | Fault lamp drive, 1 = lit |
| pass_led_on | output | 1 | Pass lamp drive, 1 = lit |

## Verification
The hardest situation to reach from the ports is a press edge that meets a changing enable state. This covers a press that is accepted while the function is disabled, and a button that is already held when the function is enabled, where only a fresh release-and-press may count. The bench builds the design with a three-bit debounce counter so that the acceptance window lasts only eight cycles. It then holds the button for a counted number of cycles around the enable and disable writes, and also applies glitches shorter than the window. Both registers are also swept over all 256 write values, with the jumper in each state.

// File: rtl/fpal_pkg.sv
// Package: shared widths and field positions of the front-panel abort and
// LED control block. The positions below are what software decodes.
package fpal_pkg;
    localparam int REG_W          = 8;
    // abort register fields
    localparam int ABT_PEND_BIT   = 4;
    localparam int ABT_EN_BIT     = 5;
    localparam int ABT_CMOS_BIT   = 7;
    // lamp register fields
    localparam int LED_FAULT_BIT  = 0;
    localparam int LED_PASS_BIT   = 1;
    localparam int LED_FIELD_W    = 2;
endpackage

// File: rtl/fpal_sync.sv
// Module: fpal_sync
// Carries an asynchronous single-bit level into the clk domain through a
// chain of STAGES flops. Assumes the input is a slow level (button, jumper).
module fpal_sync #(
    parameter int  STAGES    = 2,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fpal_debounce.sv
// Module: fpal_debounce
// Accepts a new level only after the synchronized input has disagreed with
// the accepted level for 2**CNT_W consecutive cycles. Emits a one-cycle pulse
// in the cycle the accepted level goes from 0 to 1. Assumes the input is
// already synchronous to clk.
module fpal_debounce #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out,
    output logic rise_pulse
);
    logic [CNT_W-1:0] run_cnt;
    logic             differ;
    logic             window_done;

    assign differ      = (level_in != level_out);
    assign window_done = &run_cnt;

    // count the run of disagreeing cycles and flip the accepted level at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            level_out <= 1'b0;
        end else if (!differ) begin
            run_cnt   <= '0;
        end else if (window_done) begin
            run_cnt   <= '0;
            level_out <= level_in;
        end else begin
            run_cnt   <= run_cnt + 1'b1;
        end
    end

    // mark the cycle in which the accepted level becomes pressed
    always_ff @(posedge clk) begin
        if (!rst_n) rise_pulse <= 1'b0;
        else        rise_pulse <= differ && window_done && level_in;
    end
endmodule

// File: rtl/fpal_regs.sv
// Module: fpal_regs
// Holds the abort enable, the sticky pending flag and the two lamp bits, and
// forms the read images of both registers. Assumes press_pulse is a single
// cycle wide and cmos_fitted is synchronous.
module fpal_regs
    import fpal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_abort,
    input  logic             wr_led,
    input  logic [REG_W-1:0] wdata,
    input  logic             press_pulse,
    input  logic             cmos_fitted,
    output logic             abort_en,
    output logic             abort_pend,
    output logic [LED_FIELD_W-1:0] led_q,
    output logic [REG_W-1:0] abort_img,
    output logic [REG_W-1:0] led_img
);
    // enable bit: set by writing 1, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)        abort_en <= 1'b0;
        else if (wr_abort) abort_en <= wdata[ABT_EN_BIT];
    end

    // sticky pending flag: a disabling write wins over a same-cycle press
    always_ff @(posedge clk) begin
        if (!rst_n)                              abort_pend <= 1'b0;
        else if (wr_abort && !wdata[ABT_EN_BIT]) abort_pend <= 1'b0;
        else if (press_pulse && abort_en)        abort_pend <= 1'b1;
    end

    // lamp bits: reset leaves both lamps lit (fault bit 0, pass bit 1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q                <= '0;
            led_q[LED_PASS_BIT]  <= 1'b1;
        end else if (wr_led) begin
            led_q <= wdata[LED_FIELD_W-1:0];
        end
    end

    // read image of the abort register
    always_comb begin
        abort_img               = '0;
        abort_img[ABT_PEND_BIT] = abort_pend;
        abort_img[ABT_EN_BIT]   = abort_en;
        abort_img[ABT_CMOS_BIT] = !cmos_fitted;
    end

    // read image of the lamp register
    always_comb begin
        led_img                   = '0;
        led_img[LED_FIELD_W-1:0]  = led_q;
    end
endmodule

// File: rtl/fp_abort_led.sv
// Module: fp_abort_led
// Front-panel abort button and health lamp controller behind a byte port.
// Assumes a single clock, synchronous active-low reset, and that register
// reads are sampled combinationally while a select is held.
module fp_abort_led
    import fpal_pkg::*;
#(
    parameter int DEBOUNCE_BITS = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_abort,
    input  logic             sel_led,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             abort_btn_raw,
    input  logic             cmos_jumper_fitted,
    output logic             abort_irq,
    output logic             fault_led_on,
    output logic             pass_led_on
);
    logic btn_sync;
    logic btn_level;
    logic press_pulse;
    logic jmp_sync;
    logic abort_en;
    logic abort_pend;
    logic [LED_FIELD_W-1:0] led_q;
    logic [REG_W-1:0] abort_img;
    logic [REG_W-1:0] led_img;

    fpal_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) btn_sync_i (
        .clk(clk), .rst_n(rst_n), .din(abort_btn_raw), .dout(btn_sync)
    );

    fpal_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) jmp_sync_i (
        .clk(clk), .rst_n(rst_n), .din(cmos_jumper_fitted), .dout(jmp_sync)
    );

    fpal_debounce #(.CNT_W(DEBOUNCE_BITS)) deb_i (
        .clk(clk), .rst_n(rst_n), .level_in(btn_sync),
        .level_out(btn_level), .rise_pulse(press_pulse)
    );

    fpal_regs regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_abort(wr_en && sel_abort), .wr_led(wr_en && sel_led),
        .wdata(wdata), .press_pulse(press_pulse), .cmos_fitted(jmp_sync),
        .abort_en(abort_en), .abort_pend(abort_pend), .led_q(led_q),
        .abort_img(abort_img), .led_img(led_img)
    );

    // read mux: the abort register has priority when both are selected
    always_comb begin
        if (sel_abort)    rdata = abort_img;
        else if (sel_led) rdata = led_img;
        else              rdata = '0;
    end

    assign abort_irq    = abort_pend && abort_en;
    assign fault_led_on = !led_q[LED_FAULT_BIT];
    assign pass_led_on  = led_q[LED_PASS_BIT];
endmodule

// File: rtl/fpal_checker.sv
// Module: fpal_checker
// Temporal checks on the abort and lamp controller, bound to fp_abort_led.
module fpal_checker
    import fpal_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sel_abort,
    input logic             sel_led,
    input logic             wr_en,
    input logic [REG_W-1:0] wdata,
    input logic             abort_irq,
    input logic             fault_led_on,
    input logic             pass_led_on,
    input logic             abort_en,
    input logic             abort_pend,
    input logic             btn_sync,
    input logic             btn_level
);
    logic wr_a;
    logic wr_l;
    assign wr_a = wr_en && sel_abort;
    assign wr_l = wr_en && sel_led;

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq |-> abort_en);

    assert_clear_on_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !wdata[ABT_EN_BIT]) |=> (!abort_irq && !abort_pend));

    assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && wdata[ABT_EN_BIT]) |=> abort_en);

    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pend && !(wr_a && !wdata[ABT_EN_BIT])) |=> abort_pend);

    assert_debounce_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(btn_level) |-> $past(btn_sync));

    assert_pend_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_pend) |-> $past(abort_en));

    assert_lamp_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_l |=> (fault_led_on == !$past(wdata[LED_FAULT_BIT]) &&
                  pass_led_on  ==  $past(wdata[LED_PASS_BIT])));
endmodule

bind fp_abort_led fpal_checker chk_i (
    .clk(clk), .rst_n(rst_n), .sel_abort(sel_abort), .sel_led(sel_led),
    .wr_en(wr_en), .wdata(wdata), .abort_irq(abort_irq),
    .fault_led_on(fault_led_on), .pass_led_on(pass_led_on),
    .abort_en(abort_en), .abort_pend(abort_pend),
    .btn_sync(btn_sync), .btn_level(btn_level)
);

// File: tb/fp_abort_led_tb.sv
`timescale 1ns/1ps
module fp_abort_led_tb_top;
    localparam int DEB = 3;          // window of 8 cycles
    localparam int WIN = 1 << DEB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_abort = 1'b0, sel_led = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       btn = 1'b0, jmp = 1'b0;
    logic       irq, fault_on, pass_on;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    fp_abort_led #(.DEBOUNCE_BITS(DEB)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_abort(sel_abort), .sel_led(sel_led),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .abort_btn_raw(btn), .cmos_jumper_fitted(jmp),
        .abort_irq(irq), .fault_led_on(fault_on), .pass_led_on(pass_on)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic l, input logic [7:0] d);
        @(negedge clk);
        sel_abort = a; sel_led = l; wr_en = 1'b1; wdata = d;
        @(negedge clk);
        sel_abort = 1'b0; sel_led = 1'b0; wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic a, input logic l, output logic [7:0] v);
        @(negedge clk);
        sel_abort = a; sel_led = l;
        #1 v = rdata;
        sel_abort = 1'b0; sel_led = 1'b0;
    endtask

    function automatic logic [7:0] abort_exp(input logic j, input logic en, input logic pend);
        return {~j, 1'b0, en, pend, 4'b0000};
    endfunction

    initial begin
        logic [7:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(1, 0, v); chk("R1 abort reg", v, 8'h80);
        rd(0, 1, v); chk("R1 led reg", v, 8'h02);
        chk("R1 lamps", {6'b0, fault_on, pass_on}, 8'h03);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R2 sweep of the LED register
        for (int i = 0; i < 256; i++) begin
            wr(0, 1, 8'(i));
            rd(0, 1, v); chk("R2 led readback", v, 8'(i) & 8'h03);
            chk("R2 lamps", {6'b0, fault_on, pass_on}, {6'b0, ~i[0], i[1]});
        end

        // R3 R8 sweep of the abort register with both jumper states
        for (int j = 0; j < 2; j++) begin
            jmp = j[0];
            cyc(4);
            for (int i = 0; i < 256; i++) begin
                wr(1, 0, 8'(i));
                rd(1, 0, v); chk("R3/R8 abort readback", v, abort_exp(j[0], i[5], 1'b0));
                chk("R7 irq idle", {7'b0, irq}, 8'h00);
            end
        end
        jmp = 1'b0; cyc(4);

        // R9 select priority and empty read
        wr(0, 1, 8'h01);
        wr(1, 0, 8'h20);
        rd(1, 1, v); chk("R9 both selected", v, 8'hA0);
        rd(0, 0, v); chk("R9 none selected", v, 8'h00);
        wr(1, 1, 8'h02);
        rd(0, 1, v); chk("R9 dual write led", v, 8'h02);
        rd(1, 0, v); chk("R9 dual write abort", v, 8'h80);

        // R4 glitch shorter than the window is ignored
        wr(1, 0, 8'h20);
        btn = 1'b1; cyc(WIN / 2); btn = 1'b0; cyc(3 * WIN);
        rd(1, 0, v); chk("R4 short glitch", v, 8'hA0);
        btn = 1'b1; cyc(WIN - 1); btn = 1'b0; cyc(3 * WIN);
        rd(1, 0, v); chk("R4 glitch one below window", v, 8'hA0);

        // R5 R7 accepted press sets sticky flag and irq
        btn = 1'b1; cyc(3 * WIN);
        rd(1, 0, v); chk("R5 press sets pending", v, 8'hB0);
        chk("R7 irq on press", {7'b0, irq}, 8'h01);
        btn = 1'b0; cyc(3 * WIN);
        rd(1, 0, v); chk("R5 sticky after release", v, 8'hB0);
        wr(1, 0, 8'h20);
        rd(1, 0, v); chk("R5 rewrite enable keeps flag", v, 8'hB0);

        // R6 disabling write clears flag and irq
        wr(1, 0, 8'h00);
        rd(1, 0, v); chk("R6 cleared", v, 8'h80);
        chk("R6 irq low", {7'b0, irq}, 8'h00);

        // R10 press while disabled is ignored
        btn = 1'b1; cyc(3 * WIN); btn = 1'b0; cyc(3 * WIN);
        rd(1, 0, v); chk("R10 press while disabled", v, 8'h80);

        // R10 R5 enabling while held does not count; a fresh press does
        btn = 1'b1; cyc(3 * WIN);
        wr(1, 0, 8'h20); cyc(3 * WIN);
        rd(1, 0, v); chk("R10 enable while held", v, 8'hA0);
        chk("R7 no irq while held", {7'b0, irq}, 8'h00);
        btn = 1'b0; cyc(3 * WIN);
        btn = 1'b1; cyc(3 * WIN);
        rd(1, 0, v); chk("R5 fresh press", v, 8'hB0);
        chk("R7 irq fresh press", {7'b0, irq}, 8'h01);

        // R8 jumper fitted with flag set
        jmp = 1'b1; cyc(4);
        rd(1, 0, v); chk("R8 jumper fitted", v, 8'h30);
        btn = 1'b0;
        wr(1, 0, 8'hDF);
        rd(1, 0, v); chk("R6/R8 write 0xDF", v, 8'h00);
        chk("R6 irq after clear", {7'b0, irq}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule